// File: doc/BRIEF.md
# Baud Divisor Clock-Crossing Register

This block sits on the register side of a 16550-style UART. It holds the 16-bit baud divisor, which software writes over a simple APB-like port clocked by the bus clock. It carries each accepted divisor value into the separate UART serial clock domain, where the baud generator reads it as a plain parallel output. The crossing uses a toggle request and a toggle acknowledge, each passed through a multi-flop synchronizer. The value on the wires between the domains stays frozen from launch until the acknowledge comes back.

A mode bit in a control register picks the register layout. With the bit clear, the divisor is split into a low byte and a high byte at two legacy offsets, and FIFO control has its own legacy offset. With the bit set, the whole divisor sits in one word and FIFO control moves next to it, while the legacy offsets read as zero and ignore writes. A sticky flag tells software that a divisor written in the new mode has reached the serial domain.

The transfer engine is a three-state machine in the bus domain:
- ST_IDLE: nothing is in flight.
- ST_BUSY: one request is outstanding.
- ST_QUEUED: a request is outstanding and a newer value waits behind it.

The transitions are:
- launch (ST_IDLE to ST_BUSY, on an accepted divisor write).
- finish (ST_BUSY to ST_IDLE, when the acknowledge arrives and no write is present).
- relaunch (ST_BUSY to ST_BUSY, when the acknowledge and a new write arrive together).
- enqueue (ST_BUSY to ST_QUEUED, on a write before the acknowledge).
- drain (ST_QUEUED to ST_BUSY, when the acknowledge arrives and the newest value is launched).

Top module: `baud_div_cdc`

## Requirements
- R1: After reset, the divisor is 0x0002 both in register reads and on `udiv_o`. The mode bit, the done flag and the FIFO control value are all 0.
- R2: With the mode bit at 0, legacy layout applies:
  - The divisor low byte is at offset 0x00, in data bits 7:0.
  - The divisor high byte is at offset 0x04, in data bits 7:0.
  - FIFO control is read/write at offset 0x08.
  - FIFO control is also readable at offset 0x34, but writes there are ignored.
  - Offset 0x30 reads zero and ignores writes.
- R3: With the mode bit at 1, new layout applies:
  - The full divisor is read/write at offset 0x30, in bits 15:0.
  - FIFO control is read/write at offset 0x34.
  - Offsets 0x00, 0x04 and 0x08 read zero and ignore writes.
- R4: The control register is at offset 0x38. Bit 0 is the mode bit and is read/write. Bit 1 is the done flag and is read-only.
- R5: Every accepted divisor write that is not overtaken by a later one appears on `udiv_o` with its exact value. Values appear in the order they were written.
- R6: The done flag sets when a transfer completes with no newer write waiting, but only if that transfer was launched while the mode bit was 1. Transfers launched in legacy mode never set it.
- R7: Any write to offset 0x38 clears the done flag. Any accepted divisor write also clears it.
- R8: A divisor write that arrives while a transfer is in flight is held until that transfer completes. If further writes arrive first, only the newest held value is sent, and overwritten values never appear on `udiv_o`.
- R9: While `line_busy_i` is 1, divisor writes are ignored: the register does not change and no transfer starts. Control and FIFO-control writes still take effect.
- R10: The value crossing to the serial domain stays stable from each launch until the next launch.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Bus-domain reset, active low |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset of the register |
| pwdata | input | REG_W | Write data |
| prdata | output | REG_W | Read data (combinational on the offset) |
| line_busy_i | input | 1 | Serial transmit or receive in progress (bus domain) |
| fifo_ctrl_o | output | FCR_W | FIFO control value for the FIFO logic |
| sync_done_o | output | 1 | Sticky flag: the divisor has reached the serial domain |
| uclk | input | 1 | UART serial clock |
| urstn | input | 1 | Serial-domain reset, active low |
| udiv_o | output | DIV_W | Divisor in the serial clock domain |

## Verification
The hardest case to reach from the ports is the ST_QUEUED state, and in particular a queued value being overwritten before the first transfer finishes. Only in that case must an accepted write never reach the serial side.

The bench runs the serial clock much slower than the bus clock, so that one round trip lasts well over a dozen bus cycles. It then issues three full-divisor writes back to back. A scoreboard holds only the first and the last of these values, and a monitor on the serial clock fails on any other value that shows up. The bench also checks that the done flag is raised only after the final transfer completes.

// File: rtl/bdu_pkg.sv
package bdu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BUSY   = 2'd1,
        ST_QUEUED = 2'd2
    } xfer_state_e;

    localparam int unsigned BYTE_W = 8;

    localparam logic [7:0] OFS_DIV_LO   = 8'h00;
    localparam logic [7:0] OFS_DIV_HI   = 8'h04;
    localparam logic [7:0] OFS_FIFO_OLD = 8'h08;
    localparam logic [7:0] OFS_DIV_FULL = 8'h30;
    localparam logic [7:0] OFS_FIFO_NEW = 8'h34;
    localparam logic [7:0] OFS_CTRL     = 8'h38;

    localparam int unsigned CTRL_MODE_BIT = 0;
    localparam int unsigned CTRL_DONE_BIT = 1;

endpackage

// File: rtl/bdu_sync.sv
module bdu_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    if (STAGES == 1) begin : g_single
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= RST_VAL;
            else        chain_q <= d;
        end
    end else begin : g_chain
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL}};
            else        chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/bdu_regs.sv
module bdu_regs
    import bdu_pkg::*;
#(
    parameter int unsigned    ADDR_W    = 8,
    parameter int unsigned    REG_W     = 16,
    parameter int unsigned    DIV_W     = 16,
    parameter int unsigned    FCR_W     = 8,
    parameter logic [DIV_W-1:0] DIV_RESET = 16'h0002
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [REG_W-1:0]  pwdata,
    output logic [REG_W-1:0]  prdata,
    input  logic              line_busy,
    input  logic              done_set,
    output logic              div_wr,
    output logic [DIV_W-1:0]  div_next,
    output logic [DIV_W-1:0]  div_q,
    output logic [FCR_W-1:0]  fcr_q,
    output logic              mode_new,
    output logic              sync_done
);

    localparam int unsigned HI_W = DIV_W - BYTE_W;

    logic wr_acc;
    logic hit_lo, hit_hi, hit_fifo_old, hit_full, hit_fifo_new, hit_ctrl;
    logic fcr_wr, ctrl_wr;

    assign wr_acc       = psel & penable & pwrite;
    assign hit_lo       = (paddr == ADDR_W'(OFS_DIV_LO));
    assign hit_hi       = (paddr == ADDR_W'(OFS_DIV_HI));
    assign hit_fifo_old = (paddr == ADDR_W'(OFS_FIFO_OLD));
    assign hit_full     = (paddr == ADDR_W'(OFS_DIV_FULL));
    assign hit_fifo_new = (paddr == ADDR_W'(OFS_FIFO_NEW));
    assign hit_ctrl     = (paddr == ADDR_W'(OFS_CTRL));

    assign fcr_wr  = wr_acc & ((!mode_new & hit_fifo_old) | (mode_new & hit_fifo_new));
    assign ctrl_wr = wr_acc & hit_ctrl;

    // divisor write decode: legacy byte halves or the combined word
    always_comb begin
        div_next = div_q;
        div_wr   = 1'b0;
        if (wr_acc && !line_busy) begin
            if (!mode_new && hit_lo) begin
                div_next[BYTE_W-1:0] = pwdata[BYTE_W-1:0];
                div_wr               = 1'b1;
            end else if (!mode_new && hit_hi) begin
                div_next[DIV_W-1:BYTE_W] = pwdata[HI_W-1:0];
                div_wr                   = 1'b1;
            end else if (mode_new && hit_full) begin
                div_next = pwdata[DIV_W-1:0];
                div_wr   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q     <= DIV_RESET;
            fcr_q     <= '0;
            mode_new  <= 1'b0;
            sync_done <= 1'b0;
        end else begin
            if (div_wr)  div_q    <= div_next;
            if (fcr_wr)  fcr_q    <= pwdata[FCR_W-1:0];
            if (ctrl_wr) mode_new <= pwdata[CTRL_MODE_BIT];
            if (done_set)                sync_done <= 1'b1;
            else if (ctrl_wr || div_wr)  sync_done <= 1'b0;
        end
    end

    always_comb begin
        prdata = '0;
        if (hit_lo && !mode_new) begin
            prdata[BYTE_W-1:0] = div_q[BYTE_W-1:0];
        end else if (hit_hi && !mode_new) begin
            prdata[HI_W-1:0] = div_q[DIV_W-1:BYTE_W];
        end else if (hit_fifo_old && !mode_new) begin
            prdata[FCR_W-1:0] = fcr_q;
        end else if (hit_full && mode_new) begin
            prdata[DIV_W-1:0] = div_q;
        end else if (hit_fifo_new) begin
            prdata[FCR_W-1:0] = fcr_q;
        end else if (hit_ctrl) begin
            prdata[CTRL_MODE_BIT] = mode_new;
            prdata[CTRL_DONE_BIT] = sync_done;
        end
    end

endmodule

// File: rtl/bdu_xfer_src.sv
module bdu_xfer_src
    import bdu_pkg::*;
#(
    parameter int unsigned      DIV_W     = 16,
    parameter logic [DIV_W-1:0] DIV_RESET = 16'h0002
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_next,
    input  logic [DIV_W-1:0] div_q,
    input  logic             tag_en,
    input  logic             ack_sync,
    output logic             req_tgl,
    output logic [DIV_W-1:0] xfer_data,
    output logic             done_set,
    output xfer_state_e      state
);

    xfer_state_e      state_q, state_d;
    logic             ack_in;
    logic             launch;
    logic [DIV_W-1:0] launch_val;
    logic             req_q, tag_q;
    logic [DIV_W-1:0] data_q;

    assign ack_in = (ack_sync == req_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (div_wr) state_d = ST_BUSY;
            end
            ST_BUSY: begin
                if (ack_in)      state_d = div_wr ? ST_BUSY : ST_IDLE;
                else if (div_wr) state_d = ST_QUEUED;
            end
            ST_QUEUED: begin
                if (ack_in) state_d = ST_BUSY;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        launch     = 1'b0;
        launch_val = div_next;
        done_set   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                launch = div_wr;
            end
            ST_BUSY: begin
                if (ack_in) begin
                    launch   = div_wr;
                    done_set = !div_wr && tag_q;
                end
            end
            ST_QUEUED: begin
                if (ack_in) begin
                    launch     = 1'b1;
                    launch_val = div_wr ? div_next : div_q;
                end
            end
            default: ;
        endcase
    end

    // crossing payload: only changes together with a request toggle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            tag_q  <= 1'b0;
            data_q <= DIV_RESET;
        end else if (launch) begin
            req_q  <= ~req_q;
            tag_q  <= tag_en;
            data_q <= launch_val;
        end
    end

    assign req_tgl   = req_q;
    assign xfer_data = data_q;
    assign state     = state_q;

endmodule

// File: rtl/bdu_xfer_dst.sv
module bdu_xfer_dst #(
    parameter int unsigned      DIV_W     = 16,
    parameter int unsigned      STAGES    = 2,
    parameter logic [DIV_W-1:0] DIV_RESET = 16'h0002
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_tgl,
    input  logic [DIV_W-1:0] xfer_data,
    output logic [DIV_W-1:0] udiv,
    output logic             ack_tgl
);

    logic             req_s;
    logic             seen_q;
    logic [DIV_W-1:0] udiv_q;

    bdu_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_tgl),
        .q     (req_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            udiv_q <= DIV_RESET;
        end else if (req_s != seen_q) begin
            seen_q <= req_s;
            udiv_q <= xfer_data;
        end
    end

    assign udiv    = udiv_q;
    assign ack_tgl = seen_q;

endmodule

// File: rtl/baud_div_cdc.sv
module baud_div_cdc
    import bdu_pkg::*;
#(
    parameter int unsigned      ADDR_W      = 8,
    parameter int unsigned      DIV_W       = 16,
    parameter int unsigned      REG_W       = DIV_W,
    parameter int unsigned      FCR_W       = 8,
    parameter int unsigned      SYNC_STAGES = 2,
    parameter logic [DIV_W-1:0] DIV_RESET   = 16'h0002
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [REG_W-1:0]  pwdata,
    output logic [REG_W-1:0]  prdata,
    input  logic              line_busy_i,
    output logic [FCR_W-1:0]  fifo_ctrl_o,
    output logic              sync_done_o,
    input  logic              uclk,
    input  logic              urstn,
    output logic [DIV_W-1:0]  udiv_o
);

    logic             div_wr;
    logic [DIV_W-1:0] div_next;
    logic [DIV_W-1:0] div_q;
    logic             mode_new;
    logic             done_set;
    logic             req_tgl;
    logic             ack_tgl;
    logic             ack_sync;
    logic [DIV_W-1:0] xfer_data;
    xfer_state_e      src_state;

    bdu_regs #(
        .ADDR_W    (ADDR_W),
        .REG_W     (REG_W),
        .DIV_W     (DIV_W),
        .FCR_W     (FCR_W),
        .DIV_RESET (DIV_RESET)
    ) u_regs (
        .clk       (pclk),
        .rst_n     (presetn),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .prdata    (prdata),
        .line_busy (line_busy_i),
        .done_set  (done_set),
        .div_wr    (div_wr),
        .div_next  (div_next),
        .div_q     (div_q),
        .fcr_q     (fifo_ctrl_o),
        .mode_new  (mode_new),
        .sync_done (sync_done_o)
    );

    bdu_xfer_src #(
        .DIV_W     (DIV_W),
        .DIV_RESET (DIV_RESET)
    ) u_src (
        .clk       (pclk),
        .rst_n     (presetn),
        .div_wr    (div_wr),
        .div_next  (div_next),
        .div_q     (div_q),
        .tag_en    (mode_new),
        .ack_sync  (ack_sync),
        .req_tgl   (req_tgl),
        .xfer_data (xfer_data),
        .done_set  (done_set),
        .state     (src_state)
    );

    bdu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ack_sync (
        .clk   (pclk),
        .rst_n (presetn),
        .d     (ack_tgl),
        .q     (ack_sync)
    );

    bdu_xfer_dst #(
        .DIV_W     (DIV_W),
        .STAGES    (SYNC_STAGES),
        .DIV_RESET (DIV_RESET)
    ) u_dst (
        .clk       (uclk),
        .rst_n     (urstn),
        .req_tgl   (req_tgl),
        .xfer_data (xfer_data),
        .udiv      (udiv_o),
        .ack_tgl   (ack_tgl)
    );

endmodule

// File: rtl/baud_div_cdc_chk.sv
module baud_div_cdc_chk
    import bdu_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned REG_W  = 16,
    parameter int unsigned DIV_W  = 16
) (
    input logic              pclk,
    input logic              presetn,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [REG_W-1:0]  prdata,
    input logic              line_busy_i,
    input logic              sync_done_o,
    input logic              mode_new,
    input xfer_state_e       src_state,
    input logic              req_tgl,
    input logic              ack_sync,
    input logic [DIV_W-1:0]  xfer_data
);

    // R10: payload only moves when a new request is raised
    a_r10_hold_stable: assert property (@(posedge pclk) disable iff (!presetn)
        $stable(req_tgl) |-> $stable(xfer_data));

    // R6: done rises only once the handshake has closed and the engine is idle
    a_r6_done_on_completion: assert property (@(posedge pclk) disable iff (!presetn)
        $rose(sync_done_o) |-> (ack_sync == req_tgl) && (src_state == ST_IDLE));

    // R7: a control write while idle clears the flag
    a_r7_done_clear: assert property (@(posedge pclk) disable iff (!presetn)
        (src_state == ST_IDLE && psel && penable && pwrite && paddr == ADDR_W'(OFS_CTRL))
        |=> !sync_done_o);

    // R3: legacy offsets read zero in the new layout
    a_r3_legacy_reads_zero: assert property (@(posedge pclk) disable iff (!presetn)
        (mode_new && psel && !pwrite &&
         (paddr == ADDR_W'(OFS_DIV_LO) || paddr == ADDR_W'(OFS_DIV_HI) ||
          paddr == ADDR_W'(OFS_FIFO_OLD)))
        |-> (prdata == '0));

    // R9: with the line busy an idle engine is never launched
    a_r9_busy_no_launch: assert property (@(posedge pclk) disable iff (!presetn)
        (line_busy_i && src_state == ST_IDLE) |=> (src_state == ST_IDLE));

endmodule

bind baud_div_cdc baud_div_cdc_chk #(
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W),
    .DIV_W  (DIV_W)
) chk_i (
    .pclk        (pclk),
    .presetn     (presetn),
    .psel        (psel),
    .penable     (penable),
    .pwrite      (pwrite),
    .paddr       (paddr),
    .prdata      (prdata),
    .line_busy_i (line_busy_i),
    .sync_done_o (sync_done_o),
    .mode_new    (mode_new),
    .src_state   (src_state),
    .req_tgl     (req_tgl),
    .ack_sync    (ack_sync),
    .xfer_data   (xfer_data)
);

// File: tb/baud_div_cdc_tb_top.sv
`timescale 1ns/1ps
module baud_div_cdc_tb_top;

    logic        pclk = 1'b0;
    logic        uclk = 1'b0;
    logic        presetn = 1'b0;
    logic        urstn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [15:0] pwdata = '0;
    logic [15:0] prdata;
    logic        line_busy_i = 1'b0;
    logic [7:0]  fifo_ctrl_o;
    logic        sync_done_o;
    logic [15:0] udiv_o;

    int total = 0;
    int bad   = 0;
    logic [15:0] exp_q[$];

    always #4  pclk = ~pclk;   // 125 MHz
    always #15 uclk = ~uclk;   // slow serial clock

    baud_div_cdc dut_i (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .line_busy_i(line_busy_i), .fifo_ctrl_o(fifo_ctrl_o),
        .sync_done_o(sync_done_o), .uclk(uclk), .urstn(urstn), .udiv_o(udiv_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge pclk); psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge pclk); penable = 1'b1;
        @(negedge pclk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge pclk); psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge pclk); penable = 1'b1; #1 d = prdata;
        @(negedge pclk); psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [15:0] e, input string req);
        logic [15:0] v;
        rd(a, v);
        check(v == e, req, {16'h0, v}, {16'h0, e});
    endtask

    task automatic settle();
        repeat (40) @(posedge pclk);
    endtask

    // monitor: every change on the serial-side divisor must match the scoreboard
    initial begin
        logic [15:0] last_div;
        last_div = 16'h0002;
        forever begin
            @(negedge uclk);
            if (urstn && udiv_o !== last_div) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected divisor", {16'h0, udiv_o}, 32'h0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(udiv_o == e, "R5 divisor delivered", {16'h0, udiv_o}, {16'h0, e});
                end
                last_div = udiv_o;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge pclk);
        check(1'b0, "watchdog expired", 32'h0, 32'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(posedge pclk);
        presetn = 1'b1;
        urstn   = 1'b1;
        repeat (3) @(posedge pclk);

        // R1 reset state
        rd_chk(8'h00, 16'h0002, "R1 low byte");
        rd_chk(8'h04, 16'h0000, "R1 high byte");
        rd_chk(8'h38, 16'h0000, "R1 ctrl");
        rd_chk(8'h34, 16'h0000, "R1 fifo ctrl");
        check(udiv_o == 16'h0002, "R1 udiv_o", {16'h0, udiv_o}, 32'h2);

        // R2 legacy byte writes, no done flag (R6)
        exp_q.push_back(16'h0034);
        wr(8'h00, 16'h0034);
        settle();
        exp_q.push_back(16'h1234);
        wr(8'h04, 16'h0012);
        settle();
        rd_chk(8'h00, 16'h0034, "R2 low byte readback");
        rd_chk(8'h04, 16'h0012, "R2 high byte readback");
        rd_chk(8'h38, 16'h0000, "R6 no done in legacy mode");

        // R2 legacy FIFO control, alias read, blocked writes
        wr(8'h08, 16'h00C7);
        rd_chk(8'h08, 16'h00C7, "R2 fifo ctrl legacy");
        rd_chk(8'h34, 16'h00C7, "R2 fifo ctrl alias read");
        wr(8'h34, 16'h0055);
        rd_chk(8'h34, 16'h00C7, "R2 alias write ignored");
        check(fifo_ctrl_o == 8'hC7, "R2 fifo_ctrl_o", {24'h0, fifo_ctrl_o}, 32'hC7);
        wr(8'h30, 16'hBEEF);
        settle();
        rd_chk(8'h30, 16'h0000, "R2 full offset reads zero");
        rd_chk(8'h04, 16'h0012, "R2 full write ignored");

        // R3/R4 switch to new layout
        wr(8'h38, 16'h0001);
        rd_chk(8'h38, 16'h0001, "R4 mode bit");
        rd_chk(8'h00, 16'h0000, "R3 low byte blocked");
        rd_chk(8'h04, 16'h0000, "R3 high byte blocked");
        rd_chk(8'h08, 16'h0000, "R3 legacy fifo blocked");
        rd_chk(8'h30, 16'h1234, "R3 full divisor read");
        wr(8'h00, 16'h00AA);
        wr(8'h08, 16'h0000);
        settle();
        rd_chk(8'h30, 16'h1234, "R3 legacy divisor write ignored");
        rd_chk(8'h34, 16'h00C7, "R3 legacy fifo write ignored");
        wr(8'h34, 16'h0081);
        rd_chk(8'h34, 16'h0081, "R3 fifo ctrl new offset");

        // R6 done after transfer in new mode
        exp_q.push_back(16'h0A0B);
        wr(8'h30, 16'h0A0B);
        settle();
        rd_chk(8'h30, 16'h0A0B, "R3 full divisor write");
        rd_chk(8'h38, 16'h0003, "R6 done set");

        // R7 clear by control write
        wr(8'h38, 16'h0001);
        rd_chk(8'h38, 16'h0001, "R7 clear by ctrl write");
        exp_q.push_back(16'h0C0D);
        wr(8'h30, 16'h0C0D);
        settle();
        rd_chk(8'h38, 16'h0003, "R6 done set again");
        // R7 clear by divisor write
        exp_q.push_back(16'h0E0F);
        wr(8'h30, 16'h0E0F);
        rd_chk(8'h38, 16'h0001, "R7 clear by divisor write");
        settle();
        rd_chk(8'h38, 16'h0003, "R6 done after 0E0F");

        // R8 queued writes: middle value must never appear
        exp_q.push_back(16'h1111);
        exp_q.push_back(16'h3333);
        wr(8'h30, 16'h1111);
        wr(8'h30, 16'h2222);
        wr(8'h30, 16'h3333);
        rd_chk(8'h38, 16'h0001, "R8 done low while queued");
        settle();
        rd_chk(8'h30, 16'h3333, "R8 newest value held");
        rd_chk(8'h38, 16'h0003, "R8 done after final transfer");
        check(udiv_o == 16'h3333, "R8 udiv_o final", {16'h0, udiv_o}, 32'h3333);

        // R9 divisor writes ignored while the line is busy
        line_busy_i = 1'b1;
        wr(8'h30, 16'h5555);
        settle();
        rd_chk(8'h30, 16'h3333, "R9 divisor unchanged while busy");
        wr(8'h38, 16'h0001);
        rd_chk(8'h38, 16'h0001, "R9 ctrl write still works");
        line_busy_i = 1'b0;
        settle();

        check(exp_q.size() == 0, "R5 all values delivered", exp_q.size(), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule